// File: doc/BRIEF.md
# Dual Page-Size Address Translator with Hardware Walker

This block turns 32-bit linear addresses into physical addresses. It keeps two small fully associative translation caches side by side. One holds 4-KB page mappings and the other holds 4-MB mappings. Every lookup probes both caches in the same cycle. A hit produces a registered physical address for the downstream tag-check stage one cycle after the request is taken.

When neither cache holds the page, a hardware walker reads the directory entry from memory. The directory base comes from a control register that software loads. If that entry maps a 4-MB page, the walk ends there. Otherwise a second read fetches the page-table entry. The size bit of the directory entry picks which cache is filled, so both page sizes can share one directory. If an entry at either level is not present, the walk ends with a one-cycle fault indication instead of an address. Loading the control register empties both caches.

Top module: `dual_tlb_walker`

## Requirements
- R1: After reset, res_valid_o, res_fault_o and mem_req_o are low, req_ready_o is high, and both caches are empty, so the first lookup of any address starts a walk.
- R2: The first read of a walk is at address {base[31:12], lin[31:22], 2'b00}, where base is the last value written through cr3_wdata_i.
- R3: A directory entry with bit 0 (present) and bit 7 (size) set ends the walk after one read. The result is {entry[31:22], lin[21:0]}, and the 4-MB cache is filled.
- R4: A directory entry with bit 0 set and bit 7 clear causes a second read, at {entry[31:12], lin[21:12], 2'b00}. If that table entry has bit 0 set, the result is {table_entry[31:12], lin[11:0]}, and the 4-KB cache is filled.
- R5: If bit 0 is clear in the entry at either level, res_fault_o pulses for one cycle, res_valid_o stays low and no cache is filled, so repeating the lookup walks again.
- R6: A lookup that hits produces res_valid_o with res_hit_o high in the cycle after acceptance, and issues no memory read.
- R7: A filled 4-MB entry serves every address in its 4-MB region. A filled 4-KB entry serves only its own 4-KB page.
- R8: A write through cr3_we_i invalidates all entries in both caches, and req_ready_o is low in the cycle of the write.
- R9: Each cache has 4 ways with round-robin replacement. After five distinct fills into one cache, the first page filled is evicted and the other four still hit.
- R10: mem_req_o, once raised, stays high with a stable mem_addr_o until the cycle in which mem_ack_i is seen.
- R11: req_ready_o is low while a walk is in progress. A walk's result (address or fault, with res_hit_o low) appears in the cycle after the acknowledge of its last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cr3_we_i | input | 1 | Load the directory base register and flush both caches |
| cr3_wdata_i | input | 32 | New directory base; bits 31:12 are used |
| req_valid_i | input | 1 | Translation request |
| req_lin_i | input | 32 | Linear address to translate |
| req_ready_o | output | 1 | Request is accepted when this and req_valid_i are high |
| res_valid_o | output | 1 | Physical address valid for the tag-check stage (one cycle) |
| res_fault_o | output | 1 | Page fault for the last accepted request (one cycle) |
| res_hit_o | output | 1 | With res_valid_o: result came from a cache rather than a walk |
| res_pa_o | output | 32 | Physical address |
| mem_req_o | output | 1 | Walker read request |
| mem_addr_o | output | 32 | Walker read address |
| mem_ack_i | input | 1 | Read acknowledge; mem_rdata_i valid in this cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
A stale valid bit or a wrong replacement pointer shows up at the ports the next time the affected page is used. The lookup completes one cycle later with res_hit_o high when it should have started a memory read, or it starts a read when a hit was due. A corrupt tag or frame shows up as a wrong res_pa_o on the first hit after the fill. A walker that takes the wrong branch on the size or present bit shows up as a wrong read count or read address during that same walk. The bench therefore flushes before each address in a sweep across all directory entry kinds. It compares every read address, the read count, the result and the latency, and then repeats each lookup to observe what was stored.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned PRES_BIT = 0;  // present bit in both levels
  localparam int unsigned SIZE_BIT = 7;  // 4-MB page select in directory entry

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_DIR,
    WK_TBL
  } walk_state_e;
endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned PFN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PFN_W-1:0] fill_pfn_i
);
  localparam int unsigned IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [PFN_W-1:0] pfn_q [WAYS];
  logic [WAYS-1:0]  match;
  logic [IDX_W-1:0] ptr_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = valid_q[w] && (tag_q[w] == look_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= 1'b0;
        tag_q[w]   <= '0;
        pfn_q[w]   <= '0;
      end else if (flush_i) begin
        valid_q[w] <= 1'b0;
      end else if (fill_i && ptr_q == IDX_W'(w)) begin
        valid_q[w] <= 1'b1;
        tag_q[w]   <= fill_tag_i;
        pfn_q[w]   <= fill_pfn_i;
      end
    end
  end

  assign hit_o = |match;

  always_comb begin
    pfn_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) pfn_o = pfn_o | pfn_q[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (flush_i) begin
      ptr_q <= '0;
    end else if (fill_i) begin
      ptr_q <= (ptr_q == IDX_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] lin_i,
  input  logic [19:0]       dir_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              large_o,
  output logic [19:0]       frame_o
);
  walk_state_e       state_q;
  logic [ADDR_W-1:0] lin_q;
  logic [19:0]       tbl_q;
  logic              pres, big;

  assign pres = mem_rdata_i[PRES_BIT];
  assign big  = mem_rdata_i[SIZE_BIT];

  assign busy_o    = (state_q != WK_IDLE);
  assign mem_req_o = busy_o;

  always_comb begin
    mem_addr_o = '0;
    if (state_q == WK_DIR)      mem_addr_o = {dir_base_i, lin_q[31:22], 2'b00};
    else if (state_q == WK_TBL) mem_addr_o = {tbl_q, lin_q[21:12], 2'b00};
  end

  assign done_o  = mem_ack_i && ((state_q == WK_TBL) ||
                                 (state_q == WK_DIR && (!pres || big)));
  assign fault_o = done_o && !pres;
  assign large_o = (state_q == WK_DIR);
  assign frame_o = mem_rdata_i[31:12];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      lin_q   <= '0;
      tbl_q   <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (start_i) begin
          state_q <= WK_DIR;
          lin_q   <= lin_i;
        end
        WK_DIR: if (mem_ack_i) begin
          if (pres && !big) begin
            state_q <= WK_TBL;
            tbl_q   <= mem_rdata_i[31:12];
          end else begin
            state_q <= WK_IDLE;
          end
        end
        WK_TBL: if (mem_ack_i) state_q <= WK_IDLE;
        default: state_q <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_tlb_walker.sv
module dual_tlb_walker
  import tlb_pkg::*;
#(
  parameter int unsigned SMALL_WAYS = 4,
  parameter int unsigned LARGE_WAYS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cr3_we_i,
  input  logic [31:0] cr3_wdata_i,
  input  logic        req_valid_i,
  input  logic [31:0] req_lin_i,
  output logic        req_ready_o,
  output logic        res_valid_o,
  output logic        res_fault_o,
  output logic        res_hit_o,
  output logic [31:0] res_pa_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i
);
  localparam int unsigned S_TAG_W = 20;
  localparam int unsigned L_TAG_W = 10;

  logic [31:0]        cr3_q;
  logic [31:0]        lin_q;
  logic               accept, any_hit;
  logic               s_hit, l_hit;
  logic [S_TAG_W-1:0] s_pfn;
  logic [L_TAG_W-1:0] l_pfn;
  logic               walk_busy, walk_done, walk_fault, walk_large;
  logic [19:0]        walk_frame;
  logic               s_fill, l_fill;

  logic        res_valid_q, res_fault_q, res_hit_q;
  logic [31:0] res_pa_q;

  assign req_ready_o = !walk_busy && !cr3_we_i;
  assign accept      = req_valid_i && req_ready_o;
  assign any_hit     = s_hit || l_hit;
  assign s_fill      = walk_done && !walk_fault && !walk_large;
  assign l_fill      = walk_done && !walk_fault && walk_large;

  tlb_array #(.WAYS(SMALL_WAYS), .TAG_W(S_TAG_W), .PFN_W(S_TAG_W)) u_small (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (cr3_we_i),
    .look_tag_i (req_lin_i[31:12]),
    .hit_o      (s_hit),
    .pfn_o      (s_pfn),
    .fill_i     (s_fill),
    .fill_tag_i (lin_q[31:12]),
    .fill_pfn_i (walk_frame)
  );

  tlb_array #(.WAYS(LARGE_WAYS), .TAG_W(L_TAG_W), .PFN_W(L_TAG_W)) u_large (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (cr3_we_i),
    .look_tag_i (req_lin_i[31:22]),
    .hit_o      (l_hit),
    .pfn_o      (l_pfn),
    .fill_i     (l_fill),
    .fill_tag_i (lin_q[31:22]),
    .fill_pfn_i (walk_frame[19:10])
  );

  page_walker u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept && !any_hit),
    .lin_i       (req_lin_i),
    .dir_base_i  (cr3_q[31:12]),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (walk_busy),
    .done_o      (walk_done),
    .fault_o     (walk_fault),
    .large_o     (walk_large),
    .frame_o     (walk_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr3_q <= '0;
      lin_q <= '0;
    end else begin
      if (cr3_we_i) cr3_q <= cr3_wdata_i;
      if (accept)   lin_q <= req_lin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_fault_q <= 1'b0;
      res_hit_q   <= 1'b0;
      res_pa_q    <= '0;
    end else begin
      res_valid_q <= 1'b0;
      res_fault_q <= 1'b0;
      if (accept && any_hit) begin
        res_valid_q <= 1'b1;
        res_hit_q   <= 1'b1;
        // 4-KB entry takes priority should both ever match
        res_pa_q    <= s_hit ? {s_pfn, req_lin_i[11:0]} : {l_pfn, req_lin_i[21:0]};
      end else if (walk_done) begin
        res_hit_q <= 1'b0;
        if (walk_fault) begin
          res_fault_q <= 1'b1;
        end else begin
          res_valid_q <= 1'b1;
          res_pa_q    <= walk_large ? {walk_frame[19:10], lin_q[21:0]}
                                    : {walk_frame, lin_q[11:0]};
        end
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_fault_o = res_fault_q;
  assign res_hit_o   = res_hit_q;
  assign res_pa_o    = res_pa_q;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cr3_we_i,
  input logic [31:0] cr3_q,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        res_valid_o,
  input logic        res_fault_o,
  input logic        res_hit_o,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i
);
  logic accept;
  assign accept = req_valid_i && req_ready_o;

  AST_OUTCOME_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && res_fault_o)); // R5

  AST_HIT_OR_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (res_valid_o && res_hit_o) || mem_req_o); // R6

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R10

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R11

  AST_FLUSH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr3_we_i |-> !req_ready_o); // R8

  AST_DIR_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> mem_addr_o[31:12] == cr3_q[31:12]); // R2

  AST_WALK_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) |-> (res_valid_o || res_fault_o) && !res_hit_o); // R11
endmodule

bind dual_tlb_walker tlb_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cr3_we_i    (cr3_we_i),
  .cr3_q       (cr3_q),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .res_valid_o (res_valid_o),
  .res_fault_o (res_fault_o),
  .res_hit_o   (res_hit_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/dual_tlb_walker_test.sv
module dual_tlb_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0001_0123;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cr3_we = 1'b0;
  logic [31:0] cr3_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        req_ready_o, res_valid_o, res_fault_o, res_hit_o;
  logic [31:0] res_pa_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0, cyc = 0, last_ack_cyc = 0, rd_cnt = 0, rd_total = 0;
  logic [31:0] addr_log [4];
  bit finished = 0;

  dual_tlb_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .cr3_we_i(cr3_we), .cr3_wdata_i(cr3_wdata),
    .req_valid_i(req_valid), .req_lin_i(req_lin), .req_ready_o(req_ready_o),
    .res_valid_o(res_valid_o), .res_fault_o(res_fault_o), .res_hit_o(res_hit_o),
    .res_pa_o(res_pa_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] pde_of(int d);
    case (d % 4)
      0:       return 32'h000A_B080;                     // size set, not present
      1:       return {10'(d) ^ 10'h155, 10'h3FF, 12'h081};
      default: return {20'h00100 + 20'(d), 12'h001};
    endcase
  endfunction

  function automatic logic [31:0] pte_of(int d, int i);
    if (i % 8 == 7) return 32'h0000_0F00;
    return {20'((d << 10) ^ (i * 37) ^ 32'h80000), 12'h001};
  endfunction

  function automatic logic [31:0] mem_of(logic [31:0] a);
    if (a[31:12] == BASE[31:12]) return pde_of(int'(a[11:2]));
    return pte_of(int'(a[31:12] - 20'h00100), int'(a[11:2]));
  endfunction

  // memory responder with varying latency
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_o) begin
        repeat (rd_total % 3) @(negedge clk);
        if (rd_cnt < 4) addr_log[rd_cnt] = mem_addr_o;
        mem_rdata = mem_of(mem_addr_o);
        mem_ack = 1'b1;
        rd_cnt++;
        rd_total++;
        last_ack_cyc = cyc + 1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_base(input logic [31:0] v, input bit look);
    @(negedge clk);
    cr3_we = 1'b1; cr3_wdata = v;
    #1;
    if (look) chk(req_ready_o == 1'b0, "R8 ready during base write", 32'(req_ready_o), 0);
    @(negedge clk);
    cr3_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] lin, output logic [31:0] pa, output logic flt,
                       output logic hit, output int nrd, output int lat);
    int n;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_lin = lin;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!(res_valid_o || res_fault_o) && n < 60) begin
      @(negedge clk);
      n++;
    end
    pa = res_pa_o; flt = res_fault_o; hit = res_hit_o; nrd = rd_cnt;
    lat = (nrd == 0) ? n - 1 : cyc - last_ack_cyc;
  endtask

  task automatic expect_walk(input logic [31:0] lin, output logic [31:0] pa, output logic flt,
                             output int nrd, output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] pde, pte;
    int d, i;
    d = int'(lin[31:22]); i = int'(lin[21:12]);
    a0 = {BASE[31:12], lin[31:22], 2'b00};
    pde = pde_of(d);
    a1 = {pde[31:12], lin[21:12], 2'b00};
    pa = '0;
    if (!pde[0]) begin flt = 1; nrd = 1; end
    else if (pde[7]) begin flt = 0; nrd = 1; pa = {pde[31:22], lin[21:0]}; end
    else begin
      pte = pte_of(d, i);
      nrd = 2;
      flt = !pte[0];
      if (pte[0]) pa = {pte[31:12], lin[11:0]};
    end
  endtask

  logic [31:0] pa, epa, a0, a1, lin;
  logic flt, eflt, hit;
  int nrd, enrd, lat;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid_o == 0, "R1 res_valid after reset", 32'(res_valid_o), 0);
    chk(res_fault_o == 0, "R1 res_fault after reset", 32'(res_fault_o), 0);
    chk(mem_req_o == 0, "R1 mem_req after reset", 32'(mem_req_o), 0);
    chk(req_ready_o == 1, "R1 ready after reset", 32'(req_ready_o), 1);

    load_base(BASE, 1);

    // sweep: every directory entry kind, several table indices
    for (int d = 0; d < 8; d++) begin
      for (int k = 0; k < 4; k++) begin
        int i;
        i = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 7 : 12;
        lin = {10'(d), 10'(i), 12'hABC ^ 12'(k * 12'h111)};
        load_base(BASE, 0);
        expect_walk(lin, epa, eflt, enrd, a0, a1);
        xlate(lin, pa, flt, hit, nrd, lat);
        chk(nrd == enrd, "R3/R4 read count", 32'(nrd), 32'(enrd));
        chk(addr_log[0] == a0, "R2 directory read address", addr_log[0], a0);
        if (enrd == 2) chk(addr_log[1] == a1, "R4 table read address", addr_log[1], a1);
        chk(flt == eflt, "R5 fault flag", 32'(flt), 32'(eflt));
        if (!eflt) chk(pa == epa, "R3/R4 walked address", pa, epa);
        chk(hit == 0 && lat == 0, "R11 walk result timing", 32'(lat), 0);
        xlate(lin, pa, flt, hit, nrd, lat);
        if (eflt) begin
          chk(flt == 1 && nrd == enrd, "R5 no fill after fault", 32'(nrd), 32'(enrd));
        end else begin
          chk(hit == 1 && nrd == 0, "R6 repeat lookup hits", 32'(nrd), 0);
          chk(pa == epa && lat == 0, "R6 hit address and latency", pa, epa);
        end
      end
    end

    // R7: 4-MB region coverage, 4-KB page bounds
    load_base(BASE, 0);
    xlate({10'd1, 10'd0, 12'h000}, pa, flt, hit, nrd, lat);
    lin = {10'd1, 10'h2F0, 12'h456};
    xlate(lin, pa, flt, hit, nrd, lat);
    expect_walk(lin, epa, eflt, enrd, a0, a1);
    chk(hit == 1 && nrd == 0, "R7 large region hit", 32'(nrd), 0);
    chk(pa == epa, "R7 large region address", pa, epa);
    xlate({10'd2, 10'd3, 12'h000}, pa, flt, hit, nrd, lat);
    lin = {10'd2, 10'd3, 12'hFFF};
    xlate(lin, pa, flt, hit, nrd, lat);
    chk(hit == 1 && nrd == 0, "R7 same small page hits", 32'(nrd), 0);
    xlate({10'd2, 10'd4, 12'h000}, pa, flt, hit, nrd, lat);
    chk(hit == 0 && nrd == 2, "R7 neighbour small page walks", 32'(nrd), 2);

    // R9: round robin in the 4-KB cache
    load_base(BASE, 0);
    for (int i = 0; i < 5; i++) xlate({10'd2, 10'(i), 12'h010}, pa, flt, hit, nrd, lat);
    for (int i = 1; i < 5; i++) begin
      xlate({10'd2, 10'(i), 12'h010}, pa, flt, hit, nrd, lat);
      chk(hit == 1 && nrd == 0, "R9 recent fills kept", 32'(nrd), 0);
    end
    xlate({10'd2, 10'd0, 12'h010}, pa, flt, hit, nrd, lat);
    chk(hit == 0 && nrd == 2, "R9 oldest fill evicted", 32'(nrd), 2);

    // R9: round robin in the 4-MB cache
    load_base(BASE, 0);
    for (int j = 0; j < 5; j++) xlate({10'(1 + 4 * j), 22'h0}, pa, flt, hit, nrd, lat);
    for (int j = 1; j < 5; j++) begin
      xlate({10'(1 + 4 * j), 22'h1234}, pa, flt, hit, nrd, lat);
      chk(hit == 1 && nrd == 0, "R9 large recent fills kept", 32'(nrd), 0);
    end
    xlate({10'd1, 22'h0}, pa, flt, hit, nrd, lat);
    chk(hit == 0 && nrd == 1, "R9 large oldest evicted", 32'(nrd), 1);

    // R8: flush empties both caches
    xlate({10'd6, 10'd1, 12'h0}, pa, flt, hit, nrd, lat);
    load_base(BASE, 1);
    xlate({10'd1, 22'h0}, pa, flt, hit, nrd, lat);
    chk(hit == 0 && nrd == 1, "R8 large flushed", 32'(nrd), 1);
    xlate({10'd6, 10'd1, 12'h0}, pa, flt, hit, nrd, lat);
    chk(hit == 0 && nrd == 2, "R8 small flushed", 32'(nrd), 2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 32'(cyc), 32'(0));
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule